// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns activity on general-purpose input pins into interrupt requests for a small processor sitting on a simple register bus. Sixteen pin-change inputs form two groups of eight. Each group has its own per-pin enable mask. Any logic change on an enabled pin of a group sets that group's sticky flag. A separate dedicated interrupt pin can be set to sense a low level, any change, a falling edge or a rising edge.

There are three flags, one per source. Each flag is combined with its own source enable and with the processor's global interrupt enable to form one request line per source. A flag clears when the processor acknowledges that source's vector, or when software writes a one to the flag's bit.

All pins pass through a two-stage synchronizer. Events are found by comparing the synchronized value with its value one clock earlier. Register reads are combinational. Register writes take effect at the next clock edge.

Top module: `xint_pinchg_ctrl`

## Requirements
- R1: A logic change on a pin of bits 7..0 whose mask bit is set sets the group-0 flag. A logic change on a pin of bits 15..8 whose mask bit is set sets the group-1 flag. In the flag register, bit 1 is group 0, bit 2 is group 1 and bit 0 is the dedicated pin.
- R2: A pin whose mask bit is clear never sets its group flag.
- R3: Request bit 1 (group 0) and request bit 2 (group 1) are high exactly when the group flag, the group enable and `glb_ie_i` are all set.
- R4: A one-cycle `ack_i` with `ack_src_i` = 0 (dedicated pin), 1 (group 0) or 2 (group 1) clears only that flag. Index 3 clears nothing.
- R5: Writing the flag register (address 3) clears every flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R6: Sense code 00 (low level) holds the dedicated flag at zero, and it reads zero. In this mode, request bit 0 is high while the synchronized pin is low and both the dedicated enable and `glb_ie_i` are set.
- R7: Sense codes 01 (any change), 10 (falling edge) and 11 (rising edge) set the dedicated flag on the selected transition only. Request bit 0 is then the flag ANDed with the dedicated enable and `glb_ie_i`.
- R8: The mask registers sit at address 0 (pins 7..0) and address 1 (pins 15..8). Both reset to zero and are read/write. Bit 7 of the address-0 register always reads zero and ignores writes.
- R9: If an event and a clear (ack or write-one) reach the same flag at the same clock edge, the flag ends up set.
- R10: A pin change sampled at clock edge n sets its flag at edge n+2. The request is visible after that edge.
- R11: The control register at address 2 resets to zero. Its layout is: bit 0 dedicated enable, bit 1 group-0 enable, bit 2 group-1 enable, bits 4:3 sense code. Other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_pins_i | input | 16 | Pin-change inputs; bits 7..0 are group 0, bits 15..8 are group 1 |
| ext_pin_i | input | 1 | Dedicated interrupt pin |
| glb_ie_i | input | 1 | Global interrupt enable from the processor |
| bus_we_i | input | 1 | Register write strobe |
| bus_waddr_i | input | 2 | Write address |
| bus_wdata_i | input | 8 | Write data |
| bus_raddr_i | input | 2 | Read address |
| bus_rdata_o | output | 8 | Read data (combinational) |
| ack_i | input | 1 | Vector acknowledge pulse |
| ack_src_i | input | 2 | Acknowledged source index |
| irq_o | output | 3 | Requests: bit 0 dedicated pin, bit 1 group 0, bit 2 group 1 |

## Verification
The hardest case to reach is a flag that is being cleared at the exact edge where a new synchronized event lands on it. The clear must arrive two edges after the pin moves, because of the synchronizer and the compare stage. The directed stimulus toggles a pin, counts two falling clock edges, and only then pulses the acknowledge, so that the two coincide on purpose. A long random phase then mixes pin toggles, writes, acknowledges and global-enable changes. This lets the same collision happen by chance against both kinds of clear and in every sense mode.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
package xint_pkg;
   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_ANY  = 2'b01,
      SNS_FALL = 2'b10,
      SNS_RISE = 2'b11
   } sense_e;

   localparam int unsigned REG_AW = 2;
   localparam logic [REG_AW-1:0] A_MASK_LO = 2'd0;
   localparam logic [REG_AW-1:0] A_MASK_HI = 2'd1;
   localparam logic [REG_AW-1:0] A_CTRL    = 2'd2;
   localparam logic [REG_AW-1:0] A_FLAG    = 2'd3;

   localparam int unsigned NGRP = 2;
   localparam int unsigned NSRC = NGRP + 1;
endpackage

// File: rtl/xint_sync.sv
`timescale 1ns/1ps
module xint_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xint_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES+1];

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= '0;
            else        pipe[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= '0;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   assign q      = pipe[STAGES-1];
   assign q_prev = pipe[STAGES];
endmodule

// File: rtl/xint_chg_det.sv
`timescale 1ns/1ps
module xint_chg_det #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] mask,
   output logic         evt
);
   assign evt = |((cur ^ prev) & mask);
endmodule

// File: rtl/xint_ext_sense.sv
`timescale 1ns/1ps
module xint_ext_sense
   import xint_pkg::*;
(
   input  logic   s,
   input  logic   s_prev,
   input  sense_e mode,
   output logic   evt,
   output logic   lvl_act
);
   always_comb begin
      unique case (mode)
         SNS_ANY:  evt = s ^ s_prev;
         SNS_FALL: evt = s_prev & ~s;
         SNS_RISE: evt = ~s_prev & s;
         default:  evt = 1'b0;
      endcase
   end

   assign lvl_act = (mode == SNS_LOW) & ~s;
endmodule

// File: rtl/xint_pinchg_ctrl.sv
`timescale 1ns/1ps
module xint_pinchg_ctrl
   import xint_pkg::*;
#(
   parameter int unsigned GRP_W       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*GRP_W-1:0]   pc_pins_i,
   input  logic                 ext_pin_i,
   input  logic                 glb_ie_i,
   input  logic                 bus_we_i,
   input  logic [REG_AW-1:0]    bus_waddr_i,
   input  logic [DATA_W-1:0]    bus_wdata_i,
   input  logic [REG_AW-1:0]    bus_raddr_i,
   output logic [DATA_W-1:0]    bus_rdata_o,
   input  logic                 ack_i,
   input  logic [1:0]           ack_src_i,
   output logic [NSRC-1:0]      irq_o
);
   localparam int unsigned PIN_W = NGRP * GRP_W;
   localparam logic [GRP_W-1:0] LO_WMASK = {1'b0, {(GRP_W-1){1'b1}}};

   if (GRP_W < 2) begin : g_bad_grp
      $error("xint_pinchg_ctrl: GRP_W must be at least 2");
   end
   if (DATA_W < GRP_W || DATA_W < 5) begin : g_bad_data
      $error("xint_pinchg_ctrl: DATA_W too narrow for the register layout");
   end

   logic [GRP_W-1:0] mask_q [NGRP];
   logic [NSRC-1:0]  en_q;
   sense_e           sense_q;
   logic [NSRC-1:0]  flag_q, flag_d;

   logic [PIN_W:0]   s_all, s_prev_all;
   logic [NSRC-1:0]  src_evt, w1c, ack_clr, src_pend;
   logic             ext_lvl, lvl_mode;

   xint_sync #(.W(PIN_W + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({ext_pin_i, pc_pins_i}),
      .q      (s_all),
      .q_prev (s_prev_all)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam logic [GRP_W-1:0]  WM    = (g == 0) ? LO_WMASK : {GRP_W{1'b1}};
      localparam logic [REG_AW-1:0] MADDR = (g == 0) ? A_MASK_LO : A_MASK_HI;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               mask_q[g] <= '0;
         else if (bus_we_i && bus_waddr_i == MADDR) mask_q[g] <= bus_wdata_i[GRP_W-1:0] & WM;
      end

      xint_chg_det #(.W(GRP_W)) u_det (
         .cur  (s_all[g*GRP_W +: GRP_W]),
         .prev (s_prev_all[g*GRP_W +: GRP_W]),
         .mask (mask_q[g]),
         .evt  (src_evt[g+1])
      );
   end

   xint_ext_sense u_ext (
      .s       (s_all[PIN_W]),
      .s_prev  (s_prev_all[PIN_W]),
      .mode    (sense_q),
      .evt     (src_evt[0]),
      .lvl_act (ext_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         sense_q <= SNS_LOW;
      end else if (bus_we_i && bus_waddr_i == A_CTRL) begin
         en_q    <= bus_wdata_i[NSRC-1:0];
         sense_q <= sense_e'(bus_wdata_i[4:3]);
      end
   end

   assign lvl_mode = (sense_q == SNS_LOW);
   assign w1c      = (bus_we_i && bus_waddr_i == A_FLAG) ? bus_wdata_i[NSRC-1:0] : '0;
   assign ack_clr  = (ack_i && ack_src_i < 2'(NSRC)) ? (NSRC'(1) << ack_src_i) : '0;

   always_comb begin
      flag_d = (flag_q & ~(w1c | ack_clr)) | src_evt;
      if (lvl_mode) flag_d[0] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   assign src_pend = {flag_q[NSRC-1:1], lvl_mode ? ext_lvl : flag_q[0]};
   assign irq_o    = src_pend & en_q & {NSRC{glb_ie_i}};

   always_comb begin
      unique case (bus_raddr_i)
         A_MASK_LO: bus_rdata_o = DATA_W'(mask_q[0]);
         A_MASK_HI: bus_rdata_o = DATA_W'(mask_q[1]);
         A_CTRL:    bus_rdata_o = DATA_W'({sense_q, en_q});
         default:   bus_rdata_o = DATA_W'(flag_q & ~{{(NSRC-1){1'b0}}, lvl_mode});
      endcase
   end

   a_r6_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode |=> !flag_q[0]);

   a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_evt) |=> ((flag_q & $past(src_evt)) == $past(src_evt)));

   a_r4_ack_group0_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_src_i == 2'd1 && !src_evt[1]) |=> !flag_q[1]);

   a_r5_w1c_group1_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && bus_waddr_i == A_FLAG && bus_wdata_i[2] && !src_evt[2]) |=> !flag_q[2]);

   a_r8_lo_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q[0][GRP_W-1]);
endmodule

// File: tb/tb_xint_pinchg_ctrl.sv
`timescale 1ns/1ps
module tb_xint_pinchg_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pc_pins = '0;
   logic        ext_pin = 1'b0;
   logic        gie = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  waddr = '0;
   logic [7:0]  wdata = '0;
   logic [1:0]  raddr = '0;
   logic [7:0]  rdata;
   logic        ack = 1'b0;
   logic [1:0]  ack_src = '0;
   logic [2:0]  irq;

   int vectors = 0;
   int fails = 0;

   always #2 clk = ~clk;

   xint_pinchg_ctrl dut (
      .clk(clk), .rst_n(rst_n), .pc_pins_i(pc_pins), .ext_pin_i(ext_pin),
      .glb_ie_i(gie), .bus_we_i(we), .bus_waddr_i(waddr), .bus_wdata_i(wdata),
      .bus_raddr_i(raddr), .bus_rdata_o(rdata), .ack_i(ack), .ack_src_i(ack_src),
      .irq_o(irq)
   );

   // Behavioural reference: sample history h1 (latest) .. h3, registers, flags
   logic [7:0]  m_lo, m_hi;
   logic [4:0]  m_ctl;
   logic [2:0]  m_flg;
   logic [16:0] h1, h2, h3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lo = '0; m_hi = '0; m_ctl = '0; m_flg = '0;
         h1 = '0; h2 = '0; h3 = '0;
      end else begin
         logic [15:0] ch;
         logic [2:0]  ev, clr;
         ch    = h2[15:0] ^ h3[15:0];
         ev[1] = |(ch[7:0] & m_lo);
         ev[2] = |(ch[15:8] & m_hi);
         case (m_ctl[4:3])
            2'b01:   ev[0] = h2[16] != h3[16];
            2'b10:   ev[0] = h3[16] && !h2[16];
            2'b11:   ev[0] = !h3[16] && h2[16];
            default: ev[0] = 1'b0;
         endcase
         clr = '0;
         if (we && waddr == 2'd3) clr = wdata[2:0];
         if (ack && ack_src != 2'd3) clr[ack_src] = 1'b1;
         if (m_ctl[4:3] == 2'b00) m_flg[0] = 1'b0;
         m_flg = (m_flg & ~clr) | ev;
         if (m_ctl[4:3] == 2'b00) m_flg[0] = 1'b0;
         if (we) begin
            case (waddr)
               2'd0: m_lo = wdata & 8'h7F;
               2'd1: m_hi = wdata;
               2'd2: m_ctl = wdata[4:0];
               default: ;
            endcase
         end
         h3 = h2; h2 = h1; h1 = {ext_pin, pc_pins};
      end
   end

   function automatic logic [2:0] exp_irq();
      logic [2:0] r;
      r[0] = (m_ctl[4:3] == 2'b00) ? !h2[16] : m_flg[0];
      r[1] = m_flg[1];
      r[2] = m_flg[2];
      return r & m_ctl[2:0] & {3{gie}};
   endfunction

   function automatic logic [7:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0: return m_lo;
         2'd1: return m_hi;
         2'd2: return {3'b0, m_ctl};
         default: return {5'b0, m_flg & ((m_ctl[4:3] == 2'b00) ? 3'b110 : 3'b111)};
      endcase
   endfunction

   // Per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] ei;
         logic [7:0] er;
         ei = exp_irq();
         er = exp_rd(raddr);
         for (int b = 0; b < 3; b++) begin
            vectors++;
            if (irq[b] !== ei[b]) begin
               fails++;
               if (b == 0)
                  $display("FAIL %s irq[0] actual %0b expected %0b",
                           (m_ctl[4:3] == 2'b00) ? "R6" : "R7", irq[b], ei[b]);
               else
                  $display("FAIL R3 irq[%0d] actual %0b expected %0b", b, irq[b], ei[b]);
            end
         end
         vectors++;
         if (rdata !== er) begin
            fails++;
            $display("FAIL %s rdata@%0d actual %h expected %h",
                     (raddr < 2) ? "R8" : (raddr == 2) ? "R11" : "R1", raddr, rdata, er);
         end
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
      we = 1'b0;
      ack = 1'b0;
      raddr = raddr + 2'd1;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      step();
      we = 1'b1; waddr = a; wdata = d;
   endtask

   task automatic dchk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s directed actual %0b expected %0b", tag, act, exp);
      end
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      steps(4);
      rst_n = 1'b1;
      steps(4);                       // R8 R11 reset values via reference compare
      wr(2'd0, 8'hFF);                // R8: top bit of low mask stays zero
      wr(2'd1, 8'h0F);
      wr(2'd2, 8'h1F);                // R11: all enables, rising edge
      step(); gie = 1'b1;
      steps(2);

      // R10 / R1: latency of a pin change into the group-0 request
      step(); pc_pins[0] = 1'b1;
      step(); dchk("R10", irq[1], 1'b0);
      step(); dchk("R10", irq[1], 1'b0);
      step(); dchk("R1", irq[1], 1'b1);

      // R9: acknowledge lands on the same edge as a new event
      step(); pc_pins[0] = 1'b0;
      step();
      step(); ack = 1'b1; ack_src = 2'd1;
      step(); dchk("R9", irq[1], 1'b1);
      ack = 1'b1; ack_src = 2'd1;
      step(); dchk("R4", irq[1], 1'b0);

      // R2: masked pins do nothing (pin 12 and read-only pin 7)
      step(); pc_pins[12] = 1'b1; pc_pins[7] = 1'b1;
      steps(3);
      dchk("R2", irq[2], 1'b0);
      dchk("R8", irq[1], 1'b0);

      // R5: write-one clears, write-zero keeps
      step(); pc_pins[0] = 1'b1; pc_pins[8] = 1'b1;
      steps(3);
      dchk("R1", irq[1], 1'b1);
      dchk("R1", irq[2], 1'b1);
      we = 1'b1; waddr = 2'd3; wdata = 8'h00;
      steps(2);
      dchk("R5", irq[1], 1'b1);
      dchk("R5", irq[2], 1'b1);
      we = 1'b1; waddr = 2'd3; wdata = 8'h04;
      step();
      dchk("R5", irq[2], 1'b0);
      dchk("R5", irq[1], 1'b1);
      wr(2'd3, 8'h02);
      step();

      // R3: global enable gates the request
      step(); pc_pins[1] = 1'b1;
      steps(3);
      dchk("R3", irq[1], 1'b1);
      gie = 1'b0;
      step(); dchk("R3", irq[1], 1'b0);
      gie = 1'b1;
      step(); dchk("R3", irq[1], 1'b1);
      wr(2'd3, 8'h02);
      step();

      // R7: rising, then falling edge on the dedicated pin
      step(); ext_pin = 1'b1;
      steps(3);
      dchk("R7", irq[0], 1'b1);
      ack = 1'b1; ack_src = 2'd0;
      step(); dchk("R4", irq[0], 1'b0);
      wr(2'd2, 8'h17);
      step(); ext_pin = 1'b0;
      steps(3);
      dchk("R7", irq[0], 1'b1);
      ack = 1'b1; ack_src = 2'd0;
      step(); dchk("R4", irq[0], 1'b0);
      ext_pin = 1'b1;
      steps(3);
      dchk("R7", irq[0], 1'b0);

      // R6: low-level sense follows the synchronized pin
      wr(2'd2, 8'h07);
      step(); ext_pin = 1'b0;
      steps(2);
      dchk("R6", irq[0], 1'b1);
      ext_pin = 1'b1;
      steps(2);
      dchk("R6", irq[0], 1'b0);

      // Random mix; every cycle compared with the reference (R1-related checks named per bit)
      for (int i = 0; i < 6000; i++) begin
         step();
         if ($urandom_range(0, 3) == 0) pc_pins[$urandom_range(0, 15)] ^= 1'b1;
         if ($urandom_range(0, 5) == 0) ext_pin = ~ext_pin;
         gie = ($urandom_range(0, 7) != 0);
         if ($urandom_range(0, 9) == 0) begin
            we = 1'b1;
            waddr = 2'($urandom_range(0, 3));
            wdata = 8'($urandom_range(0, 255));
         end
         if ($urandom_range(0, 4) == 0) begin
            ack = 1'b1;
            ack_src = 2'($urandom_range(0, 3));
         end
      end
      steps(4);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule